// File: doc/BRIEF.md
# Hardwired Accumulator Processor

This block is a small single-accumulator processor with fixed control logic. A six-step phase ring sequences every instruction. A one-hot decoder on the held opcode selects the instruction. Each register load enable is the AND of one phase with one decoded instruction line. The block holds the accumulator, the address and data registers, the program counter, the opcode register, a sampled input register, an output register and a run flag. The memory is outside the block.

A machine word is 16 bits. Bits 15:12 hold the opcode and bits 11:0 hold an operand address. The memory port is a plain single-cycle interface: the address is presented, read data must come back combinationally in the same cycle, and a write happens at the clock edge that closes the cycle in which the write enable is high. The block cannot be stalled at this port, so it has no back-pressure. A one-cycle start pulse launches execution from the current program counter. A halt instruction stops the machine, and a later start resumes it at the word after the halt.

Top module: `acc_cpu_core`

## Requirements
- R1: After reset, mem_addr is 0, mem_we is 0 and out_data is 0. With no start pulse the block stays idle and leaves mem_addr and mem_we unchanged.
- R2: A start pulse while idle begins phase 1 in the next cycle. Every instruction takes exactly six cycles. A start pulse while running has no effect.
- R3: Fetch sequence: phase 1 copies the program counter to mem_addr. Phase 2 reads the word and increments the program counter. Phase 3 latches opcode bits 15:12. Resuming after a halt at address a therefore fetches address a+1.
- R4: Memory-operand instructions use address bits 11:0 in phase 4 and read the operand in phase 5. Opcode 2 loads the accumulator with the operand. Opcode 0 adds the operand modulo 2^16. Opcode 1 takes the bitwise AND.
- R5: Opcode 3 stores the accumulator at the operand address. mem_we is high for exactly one cycle, and mem_wdata equals the accumulator in that cycle.
- R6: Opcode 4 clears the accumulator. Opcode 7 complements it bitwise. Opcode 5 rotates it left by one bit, so bit 15 moves into bit 0.
- R7: Opcode 6 loads the accumulator from the input register, which samples in_data every cycle.
- R8: Opcode 9 copies the accumulator to out_data. out_data holds its value until the next such instruction.
- R9: Opcode 8 loads the program counter from bits 11:0 when the accumulator is zero. Otherwise execution continues at the next word.
- R10: Opcode 15 halts. Afterwards mem_addr stays fixed and no write happens until the next start pulse.
- R11: Opcodes 10 to 14 change neither the accumulator nor out_data, and they do not write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts or resumes execution |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (data register) |
| mem_rdata | input | 16 | Memory read data, combinational from mem_addr |
| mem_we | output | 1 | Memory write strobe |
| in_data | input | 16 | Input port, sampled into the input register every cycle |
| out_data | output | 16 | Output register |

## Verification
Directed programs drive the accumulator through chosen values to separate the operations. These values include a carry out of bit 15 on addition, a rotate that carries bit 15 into bit 0, and a complement that must differ from a clear. Conditional-jump programs take the branch on a zero accumulator and fall through on a non-zero one, and preset guard words show which path ran. One program contains only the unused opcodes and proves they have no effect. Another injects a stray start pulse mid-instruction and then resumes after a halt, which exposes any restart of the phase ring and any off-by-one in the fetch address. Seeded random straight-line programs with forward jumps are compared word for word against an instruction-level model of data memory, the output register and the store count.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;
  localparam int NPH  = 6;

  // phase indices into the one-hot phase vector
  localparam int T1 = 0;
  localparam int T2 = 1;
  localparam int T3 = 2;
  localparam int T4 = 3;
  localparam int T5 = 4;
  localparam int T6 = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_AND = 4'd1,
    OP_LDA = 4'd2,
    OP_STA = 4'd3,
    OP_CLA = 4'd4,
    OP_CIL = 4'd5,
    OP_IN  = 4'd6,
    OP_CMA = 4'd7,
    OP_JZ  = 4'd8,
    OP_OUT = 4'd9,
    OP_HLT = 4'd15
  } op_e;

  // decoded instruction line positions
  localparam int L_ADD  = 0;
  localparam int L_AND  = 1;
  localparam int L_LDA  = 2;
  localparam int L_STA  = 3;
  localparam int L_CLA  = 4;
  localparam int L_CIL  = 5;
  localparam int L_IN   = 6;
  localparam int L_CMA  = 7;
  localparam int L_JZ   = 8;
  localparam int L_OUT  = 9;
  localparam int L_HLT  = 10;
  localparam int NLINES = 11;

  localparam op_e LINE_OP [NLINES] = '{
    OP_ADD, OP_AND, OP_LDA, OP_STA, OP_CLA, OP_CIL,
    OP_IN, OP_CMA, OP_JZ, OP_OUT, OP_HLT
  };

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_mdr;
    logic mdr_from_mem;
    logic mdr_from_ac;
    logic mem_wr;
    logic pc_inc;
    logic pc_load;
    logic opc_load;
    logic ac_add;
    logic ac_and;
    logic ac_clr;
    logic ac_rol;
    logic ac_mdr;
    logic ac_in;
    logic ac_not;
    logic out_load;
    logic halt;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_timer.sv
module acc_cpu_timer
  import acc_cpu_pkg::*;
#(
  parameter int PHASES = NPH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  output logic              run,
  output logic [PHASES-1:0] phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (run && halt) begin
      run   <= 1'b0;
      phase <= '0;
    end else if (!run && start) begin
      run   <= 1'b1;
      phase <= PHASES'(1);
    end else if (run) begin
      phase <= {phase[PHASES-2:0], phase[PHASES-1]};
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase[PHASES-1]) |=> (run && phase[0])); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !halt && !phase[PHASES-1]) |=> (run && !phase[0])); // R2
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (!run && phase == '0)); // R10

endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OP_W-1:0]   opc,
  output logic [NLINES-1:0] ins
);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign ins[i] = (opc == LINE_OP[i]);
  end

endmodule

// File: rtl/acc_cpu_ctl.sv
module acc_cpu_ctl
  import acc_cpu_pkg::*;
(
  input  logic [NPH-1:0]    phase,
  input  logic [NLINES-1:0] ins,
  input  logic              ac_zero,
  output ctl_t              ctl
);

  logic mem_op;
  logic read_op;

  assign read_op = ins[L_ADD] | ins[L_AND] | ins[L_LDA];
  assign mem_op  = read_op | ins[L_STA];

  always_comb begin
    ctl              = '0;
    // fetch, common to every instruction
    ctl.mar_from_pc  = phase[T1];
    ctl.pc_inc       = phase[T2];
    ctl.opc_load     = phase[T3];
    ctl.mdr_from_mem = phase[T2] | (phase[T5] & read_op);
    // operand address and single-phase work
    ctl.mar_from_mdr = phase[T4] & mem_op;
    ctl.mdr_from_ac  = phase[T4] & ins[L_STA];
    ctl.pc_load      = phase[T4] & ins[L_JZ] & ac_zero;
    ctl.ac_clr       = phase[T4] & ins[L_CLA];
    ctl.ac_rol       = phase[T4] & ins[L_CIL];
    ctl.ac_in        = phase[T4] & ins[L_IN];
    ctl.ac_not       = phase[T4] & ins[L_CMA];
    ctl.out_load     = phase[T4] & ins[L_OUT];
    ctl.halt         = phase[T4] & ins[L_HLT];
    // memory access and execute
    ctl.mem_wr       = phase[T5] & ins[L_STA];
    ctl.ac_add       = phase[T6] & ins[L_ADD];
    ctl.ac_and       = phase[T6] & ins[L_AND];
    ctl.ac_mdr       = phase[T6] & ins[L_LDA];
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   mem_we,
  input  logic [DATA_W-1:0]      in_data,
  output logic [DATA_W-1:0]      out_data
);

  localparam int ADDR_W = DATA_W - OP_W;

  logic [DATA_W-1:0] ac, ac_nxt, mdr, inr, out_r;
  logic [ADDR_W-1:0] mar, pc;
  logic [OP_W-1:0]   opc;
  logic              run;
  logic [NPH-1:0]    phase;
  logic [NLINES-1:0] ins;
  ctl_t              ctl;

  acc_cpu_timer #(.PHASES(NPH)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .halt  (ctl.halt),
    .run   (run),
    .phase (phase)
  );

  acc_cpu_decode u_dec (
    .opc (opc),
    .ins (ins)
  );

  acc_cpu_ctl u_ctl (
    .phase   (phase),
    .ins     (ins),
    .ac_zero (ac == '0),
    .ctl     (ctl)
  );

  always_comb begin
    ac_nxt = ac;
    if (ctl.ac_add)      ac_nxt = ac + mdr;
    else if (ctl.ac_and) ac_nxt = ac & mdr;
    else if (ctl.ac_mdr) ac_nxt = mdr;
    else if (ctl.ac_clr) ac_nxt = '0;
    else if (ctl.ac_rol) ac_nxt = {ac[DATA_W-2:0], ac[DATA_W-1]};
    else if (ctl.ac_in)  ac_nxt = inr;
    else if (ctl.ac_not) ac_nxt = ~ac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac    <= '0;
      mdr   <= '0;
      inr   <= '0;
      out_r <= '0;
      mar   <= '0;
      pc    <= '0;
      opc   <= '0;
    end else begin
      ac  <= ac_nxt;
      inr <= in_data;
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_mdr) mar <= mdr[ADDR_W-1:0];
      if (ctl.mdr_from_mem)      mdr <= mem_rdata;
      else if (ctl.mdr_from_ac)  mdr <= ac;
      if (ctl.pc_inc)            pc  <= pc + 1'b1;
      else if (ctl.pc_load)      pc  <= mdr[ADDR_W-1:0];
      if (ctl.opc_load)          opc <= mdr[DATA_W-1 -: OP_W];
      if (ctl.out_load)          out_r <= ac;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = ctl.mem_wr;
  assign out_data  = out_r;

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase[T1]) |=> (mem_addr == $past(pc))); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase[T2]) |=> (pc == $past(pc) + 1'b1)); // R3
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5
  AST_WE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == ac)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(phase[T4] && ins[L_OUT])) |=> $stable(out_data)); // R8
  AST_JZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[T4] && ins[L_JZ] && ac != '0) |=> $stable(pc)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (!mem_we && $stable(mem_addr))); // R10
  AST_SPARE_OP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase[T4] && ins == '0) |=> ($stable(ac) && $stable(out_data) && !mem_we)); // R11

endmodule

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, in_data = '0, out_data;
  logic        mem_we;

  logic [15:0] mem     [0:255];
  logic [15:0] ref_mem [0:255];
  logic [15:0] ref_out;
  int checks = 0, errors = 0;
  int we_cnt = 0, we_dbl = 0;
  logic prev_we = 1'b0;

  always #10 clk = ~clk;

  acc_cpu_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .in_data(in_data), .out_data(out_data)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (mem_we && prev_we) we_dbl <= we_dbl + 1;
    prev_we <= mem_we;
  end

  function automatic logic [15:0] w(input int op, input int adr);
    return {op[3:0], adr[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // instruction-level model: returns instructions executed and stores made
  task automatic model(input logic [15:0] inval, output int n_ins, output int n_wr);
    logic [15:0] ac, iw;
    logic [11:0] pc;
    bit done;
    ac = '0; pc = '0; done = 0; n_ins = 0; n_wr = 0; ref_out = '0;
    for (int a = 0; a < 256; a++) ref_mem[a] = mem[a];
    for (int k = 0; k < 1000 && !done; k++) begin
      iw = ref_mem[pc[7:0]];
      pc = pc + 1'b1;
      n_ins++;
      case (iw[15:12])
        4'd0:  ac = ac + ref_mem[iw[7:0]];
        4'd1:  ac = ac & ref_mem[iw[7:0]];
        4'd2:  ac = ref_mem[iw[7:0]];
        4'd3:  begin ref_mem[iw[7:0]] = ac; n_wr++; end
        4'd4:  ac = '0;
        4'd5:  ac = {ac[14:0], ac[15]};
        4'd6:  ac = inval;
        4'd7:  ac = ~ac;
        4'd8:  if (ac == '0) pc = iw[11:0];
        4'd9:  ref_out = ac;
        4'd15: done = 1;
        default: ;
      endcase
    end
  endtask

  int n_ins, n_wr;

  task automatic go(input logic [15:0] inval);
    model(inval, n_ins, n_wr);
    in_data = inval;
    do_reset();
    we_cnt = 0;
    we_dbl = 0;
    pulse_start();
  endtask

  task automatic finish(input int waited);
    int mism, first;
    logic [11:0] a0;
    int w0;
    tick(6 * n_ins + 2 - waited);
    chk(out_data == ref_out, "R8 output register", out_data, ref_out);
    mism = 0; first = -1;
    for (int a = 128; a < 256; a++)
      if (mem[a] !== ref_mem[a]) begin mism++; if (first < 0) first = a; end
    chk(mism == 0, "R4 data memory", (first < 0) ? 0 : mem[first], (first < 0) ? 0 : ref_mem[first]);
    chk(we_cnt == n_wr && we_dbl == 0, "R5 store strobes", we_cnt, n_wr);
    a0 = mem_addr; w0 = we_cnt;
    tick(12);
    chk(mem_addr == a0 && we_cnt == w0, "R10 halted quiet", mem_addr, a0);
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = '0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_mem();

    // R1 reset and idle
    do_reset();
    chk(mem_addr == 0 && mem_we == 0, "R1 reset address/strobe", mem_addr, 0);
    chk(out_data == 0, "R1 reset output", out_data, 0);
    tick(10);
    chk(mem_addr == 0 && we_cnt == 0, "R1 idle without start", mem_addr, 0);

    // R4 R8: load, add with carry out, output, and, store, with fetch timing (R3)
    clear_mem();
    mem[0] = w(2, 200); mem[1] = w(0, 201); mem[2] = w(9, 0);
    mem[3] = w(1, 202); mem[4] = w(3, 203); mem[5] = w(15, 0);
    mem[200] = 16'hFFFF; mem[201] = 16'h0002; mem[202] = 16'h00FF;
    go(16'h0);
    tick(4);
    chk(mem_addr == 200, "R3 operand address after phase 4", mem_addr, 200);
    tick(3);
    chk(mem_addr == 1, "R2 six-cycle step to next fetch", mem_addr, 1);
    finish(7);
    chk(out_data == 16'h0001, "R4 add wraps modulo 2^16", out_data, 16'h0001);
    chk(mem[203] == 16'h0001, "R5 stored and result", mem[203], 16'h0001);

    // R6 rotate, complement, clear
    clear_mem();
    mem[0] = w(2, 200); mem[1] = w(5, 0); mem[2] = w(9, 0); mem[3] = w(3, 204);
    mem[4] = w(7, 0); mem[5] = w(3, 205); mem[6] = w(4, 0); mem[7] = w(3, 206);
    mem[8] = w(15, 0);
    mem[200] = 16'h8001; mem[206] = 16'h5555;
    go(16'h0);
    finish(0);
    chk(mem[204] == 16'h0003, "R6 rotate left carries bit 15", mem[204], 16'h0003);
    chk(mem[205] == 16'hFFFC, "R6 complement", mem[205], 16'hFFFC);
    chk(mem[206] == 16'h0000, "R6 clear", mem[206], 16'h0000);

    // R9 jump on zero both ways, R7 input
    clear_mem();
    mem[0] = w(2, 200); mem[1] = w(8, 4); mem[2] = w(3, 210); mem[3] = w(4, 0);
    mem[4] = w(8, 7); mem[5] = w(3, 211); mem[6] = w(15, 0); mem[7] = w(6, 0);
    mem[8] = w(3, 212); mem[9] = w(15, 0);
    mem[200] = 16'h0005; mem[211] = 16'hBEEF;
    go(16'h1234);
    finish(0);
    chk(mem[210] == 16'h0005, "R9 not taken on non-zero", mem[210], 16'h0005);
    chk(mem[211] == 16'hBEEF, "R9 taken on zero skips", mem[211], 16'hBEEF);
    chk(mem[212] == 16'h1234, "R7 input register", mem[212], 16'h1234);

    // R11 spare opcodes do nothing
    clear_mem();
    mem[0] = w(2, 200); mem[1] = w(9, 0);
    mem[2] = w(10, 200); mem[3] = w(11, 201); mem[4] = w(12, 202);
    mem[5] = w(13, 203); mem[6] = w(14, 204);
    mem[7] = w(3, 213); mem[8] = w(15, 0);
    mem[200] = 16'h0AAA; mem[201] = 16'h1111; mem[202] = 16'h2222;
    mem[203] = 16'h3333; mem[204] = 16'h4444;
    go(16'hFFFF);
    finish(0);
    chk(mem[213] == 16'h0AAA && out_data == 16'h0AAA, "R11 spare opcodes inert", mem[213], 16'h0AAA);
    chk(we_cnt == 1, "R11 no extra writes", we_cnt, 1);

    // R2 stray start mid-run ignored; R10 resume after halt
    clear_mem();
    mem[0] = w(2, 200); mem[1] = w(9, 0); mem[2] = w(15, 0);
    mem[3] = w(7, 0); mem[4] = w(9, 0); mem[5] = w(15, 0);
    mem[200] = 16'h00F0;
    go(16'h0);
    tick(3);
    pulse_start();
    finish(4);
    chk(out_data == 16'h00F0, "R2 stray start ignored", out_data, 16'h00F0);
    chk(mem_addr == 2, "R10 halt leaves address at halt word", mem_addr, 2);
    pulse_start();
    chk(mem_addr == 2, "R2 resume enters phase 1 only", mem_addr, 2);
    tick(1);
    chk(mem_addr == 3, "R3 resume fetches next word", mem_addr, 3);
    tick(30);
    chk(out_data == 16'hFF0F, "R10 resumed program runs", out_data, 16'hFF0F);

    // seeded random programs against the model
    for (int p = 0; p < 30; p++) begin
      int len;
      len = $urandom_range(5, 60);
      for (int a = 0; a < 256; a++) mem[a] = 16'($urandom());
      for (int a = 0; a < len - 1; a++) begin
        int op;
        op = $urandom_range(0, 14);
        if (op <= 3)       mem[a] = w(op, $urandom_range(128, 255));
        else if (op == 8)  mem[a] = w(8, $urandom_range(a + 1, len - 1));
        else               mem[a] = w(op, $urandom_range(0, 4095));
      end
      mem[len - 1] = w(15, 0);
      go(16'($urandom()));
      finish(0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule